// File: doc/BRIEF.md
# NAND Page Buffer and Storage Array

This block stores a small NAND-style memory and the one-page I/O buffer that goes with it. Each page has a main area and a spare area one thirty-second of its size. A command sequencer in front of the block turns bus cycles into operation requests. Each request is one `op_code` strobe carrying a page number and a column. The block stages program data in its buffer and applies it to the array. Bits can only be cleared when programming, and a whole block is erased back to ones. Data is read out one bus word per strobe.

Programming takes two steps. An opening request empties the buffer, and bus words then fill it from position zero. A commit request folds the buffer into a page at a chosen column with a bitwise AND. A copy-load request fills the buffer from a source page instead. In that mode, incoming words overwrite the buffer at a moving column, so a later commit moves the edited page to a new place. A read request fixes a start position and a remaining byte count. After that, each read strobe hands out the next bus word. Commit, erase and copy-load run one byte per cycle on an internal engine, and `busy` is high while the engine runs.

Top module: `nand_page_core`

## Requirements
- R1: After reset every array byte reads 0xFF, `busy` is low, `rd_data` is zero, and read strobes return zero until a read request is made.
- R2: A page spans PAGE_BYTES main bytes followed by PAGE_BYTES/32 spare bytes, and the spare bytes are reachable as columns PAGE_BYTES upward.
- R3: Opcode 1 empties the buffer. Each following `wr_data` word is stored at the next buffer positions from position 0, low byte at the lower position. Bytes past PAGE_BYTES+PAGE_BYTES/32 are dropped.
- R4: Opcode 2 ANDs the buffered bytes into the addressed page starting at `op_col`. Array bits only go from 1 to 0, and bytes that would pass the end of the page are not written.
- R5: Opcode 3 rounds the page number down to a multiple of 2^ERASE_SHIFT and sets every main and spare byte of those pages to 0xFF.
- R6: Opcodes 4, 5 and 6 start a read at `op_col` plus 0, PAGE_BYTES/2 or PAGE_BYTES respectively. The byte count is the page span minus that start, or PAGE_BYTES minus the start when `spare_off` is high. No bytes are read when the start is not below that limit.
- R7: Each read strobe returns the next BUS_BYTES bytes, lowest address in the low byte, and advances the position. Byte lanes past the remaining count read zero, and once the count is spent a strobe returns zero.
- R8: A read strobe with `ce_n` high returns zero and does not advance the position.
- R9: Commit, erase and copy-load requests that name a page at or beyond PAGES leave the array and `busy` untouched. A read request for such a page yields no bytes.
- R10: Opcode 7 copies the addressed page into the buffer. Later `wr_data` bytes overwrite the buffer from `op_col` upward, one position per byte, and bytes at or past the page span are dropped. A following commit writes the edited buffer to its target page.
- R11: While `busy` is high, requests and write words are ignored, and read strobes return zero without advancing.
- R12: `rd_data` keeps its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 3 | Operation code (1 open, 2 commit, 3 erase, 4/5/6 read, 7 copy-load) |
| op_row | input | ROWW | Page number for the request |
| op_col | input | COLW | Column for the request |
| spare_off | input | 1 | Leave the spare area out of a read request |
| wr_valid | input | 1 | Write word strobe |
| wr_data | input | 8*BUS_BYTES | Write word, low byte first in address order |
| ce_n | input | 1 | Chip enable, active low, for read strobes |
| rd_req | input | 1 | Read strobe |
| rd_data | output | 8*BUS_BYTES | Registered read word |
| busy | output | 1 | Engine running a commit, erase or copy-load |

## Verification
The collision that matters here is a read strobe, or a new request, that arrives while the engine is still sweeping a block during an erase. The bench arms a read on one page and starts an erase of another block. While `busy` is high it issues a read strobe and a commit request. The strobe must return zero. The held read position must then give the first word of the armed page once the engine finishes, and the erased pages must read as all ones, which shows the commit was dropped.

// File: rtl/nand_pb_pkg.sv
package nand_pb_pkg;

  typedef enum logic [2:0] {
    OPC_NONE      = 3'd0,
    OPC_FILL_OPEN = 3'd1,
    OPC_COMMIT    = 3'd2,
    OPC_ERASE     = 3'd3,
    OPC_RD_MAIN   = 3'd4,
    OPC_RD_UPPER  = 3'd5,
    OPC_RD_SPARE  = 3'd6,
    OPC_COPY_LOAD = 3'd7
  } opc_e;

  typedef enum logic [1:0] {
    BM_IDLE,
    BM_FILL,
    BM_COPY
  } bufmode_e;

  typedef enum logic [1:0] {
    EN_IDLE,
    EN_PROG,
    EN_ERASE,
    EN_LOAD
  } eng_e;

endpackage

// File: rtl/nand_pb_array.sv
module nand_pb_array #(
  parameter int TOTAL     = 528,
  parameter int AW        = 10,
  parameter int BUS_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          wa,
  input  logic [7:0]             wd,
  output logic [7:0]             wa_rdata,
  input  logic [AW-1:0]          rd_base,
  output logic [BUS_BYTES*8-1:0] rd_bytes
);

  logic [7:0] cells_q [TOTAL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) cells_q[i] <= 8'hFF;
    end else if (we) begin
      cells_q[wa] <= wd;
    end
  end

  assign wa_rdata = cells_q[wa];

  for (genvar b = 0; b < BUS_BYTES; b++) begin : g_lane
    logic [AW:0] idx;
    assign idx = {1'b0, rd_base} + (AW+1)'(b);
    assign rd_bytes[b*8 +: 8] = (idx < (AW+1)'(TOTAL)) ? cells_q[idx[AW-1:0]] : 8'h00;
  end

endmodule

// File: rtl/nand_pb_buffer.sv
module nand_pb_buffer
  import nand_pb_pkg::*;
#(
  parameter int PG_SPAN   = 66,
  parameter int CW        = 7,
  parameter int COLW      = 7,
  parameter int BUS_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   open_fill,
  input  logic                   copy_start,
  input  logic [COLW-1:0]        copy_col,
  input  logic                   seal,
  input  logic                   hw_valid,
  input  logic [BUS_BYTES*8-1:0] hw_data,
  input  logic                   eng_we,
  input  logic [CW-1:0]          eng_idx,
  input  logic [7:0]             eng_wd,
  input  logic [CW-1:0]          rd_idx,
  output logic [7:0]             rd_byte,
  output logic [CW-1:0]          fill_len
);

  logic [7:0]    data_q [PG_SPAN];
  logic [7:0]    data_n [PG_SPAN];
  logic [CW-1:0] len_q, len_n;
  logic [COLW:0] ptr_q, ptr_n;
  bufmode_e      mode_q, mode_n;

  always_comb begin
    data_n = data_q;
    len_n  = len_q;
    ptr_n  = ptr_q;
    mode_n = mode_q;
    if (open_fill) begin
      len_n  = '0;
      mode_n = BM_FILL;
    end else if (copy_start) begin
      mode_n = BM_COPY;
      ptr_n  = {1'b0, copy_col};
      len_n  = CW'(PG_SPAN);
    end else if (seal) begin
      mode_n = BM_IDLE;
    end else if (hw_valid && mode_q == BM_FILL) begin
      for (int b = 0; b < BUS_BYTES; b++) begin
        if (int'(len_q) + b < PG_SPAN) data_n[CW'(int'(len_q) + b)] = hw_data[b*8 +: 8];
      end
      len_n = (int'(len_q) + BUS_BYTES >= PG_SPAN) ? CW'(PG_SPAN) : len_q + CW'(BUS_BYTES);
    end else if (hw_valid && mode_q == BM_COPY) begin
      for (int b = 0; b < BUS_BYTES; b++) begin
        if (int'(ptr_q) + b < PG_SPAN) data_n[CW'(int'(ptr_q) + b)] = hw_data[b*8 +: 8];
      end
      ptr_n = (int'(ptr_q) + BUS_BYTES >= PG_SPAN) ? (COLW+1)'(PG_SPAN)
                                                   : ptr_q + (COLW+1)'(BUS_BYTES);
    end
    if (eng_we) data_n[eng_idx] = eng_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PG_SPAN; i++) data_q[i] <= 8'h00;
      len_q  <= '0;
      ptr_q  <= '0;
      mode_q <= BM_IDLE;
    end else begin
      data_q <= data_n;
      len_q  <= len_n;
      ptr_q  <= ptr_n;
      mode_q <= mode_n;
    end
  end

  assign rd_byte  = data_q[rd_idx];
  assign fill_len = len_q;

endmodule

// File: rtl/nand_pb_engine.sv
module nand_pb_engine
  import nand_pb_pkg::*;
#(
  parameter int PG_SPAN     = 66,
  parameter int ERASE_SHIFT = 2,
  parameter int AW          = 10,
  parameter int ROWW        = 4,
  parameter int COLW        = 7,
  parameter int CW          = 7,
  parameter int EW          = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_prog,
  input  logic            go_erase,
  input  logic            go_load,
  input  logic [ROWW-1:0] row,
  input  logic [COLW-1:0] col,
  input  logic [CW-1:0]   buf_len,
  input  logic [7:0]      mem_rdata,
  input  logic [7:0]      buf_rdata,
  output logic            busy,
  output logic            mem_we,
  output logic [AW-1:0]   mem_wa,
  output logic [7:0]      mem_wd,
  output logic            buf_we,
  output logic [CW-1:0]   buf_idx,
  output logic [7:0]      buf_wd
);

  localparam int BLK_BYTES = PG_SPAN << ERASE_SHIFT;

  eng_e            st_q, st_n;
  logic [AW-1:0]   base_q, base_n;
  logic [EW-1:0]   step_q, step_n;
  logic [EW-1:0]   last_q, last_n;
  logic [AW-1:0]   page_base;
  logic [ROWW-1:0] blk_row;
  int              room, take;

  assign page_base = AW'(row) * AW'(PG_SPAN);
  assign blk_row   = (row >> ERASE_SHIFT) << ERASE_SHIFT;

  always_comb begin
    st_n   = st_q;
    base_n = base_q;
    step_n = step_q;
    last_n = last_q;
    room   = PG_SPAN - int'(col);
    take   = (int'(buf_len) < room) ? int'(buf_len) : room;
    case (st_q)
      EN_IDLE: begin
        if (go_prog) begin
          if (int'(col) < PG_SPAN && buf_len != '0) begin
            st_n   = EN_PROG;
            base_n = page_base + AW'(col);
            step_n = '0;
            last_n = EW'(take - 1);
          end
        end else if (go_erase) begin
          st_n   = EN_ERASE;
          base_n = AW'(blk_row) * AW'(PG_SPAN);
          step_n = '0;
          last_n = EW'(BLK_BYTES - 1);
        end else if (go_load) begin
          st_n   = EN_LOAD;
          base_n = page_base;
          step_n = '0;
          last_n = EW'(PG_SPAN - 1);
        end
      end
      default: begin
        if (step_q == last_q) begin
          st_n   = EN_IDLE;
          step_n = '0;
        end else begin
          step_n = step_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EN_IDLE;
      base_q <= '0;
      step_q <= '0;
      last_q <= '0;
    end else begin
      st_q   <= st_n;
      base_q <= base_n;
      step_q <= step_n;
      last_q <= last_n;
    end
  end

  assign busy    = (st_q != EN_IDLE);
  assign mem_wa  = base_q + AW'(step_q);
  assign buf_idx = CW'(step_q);
  assign mem_we  = (st_q == EN_PROG) || (st_q == EN_ERASE);
  assign mem_wd  = (st_q == EN_PROG) ? (mem_rdata & buf_rdata) : 8'hFF;
  assign buf_we  = (st_q == EN_LOAD);
  assign buf_wd  = mem_rdata;

endmodule

// File: rtl/nand_page_core.sv
module nand_page_core
  import nand_pb_pkg::*;
#(
  parameter int PAGE_BYTES  = 64,
  parameter int PAGES       = 8,
  parameter int ERASE_SHIFT = 2,
  parameter int BUS_BYTES   = 2,
  localparam int SPARE_BYTES = PAGE_BYTES >> 5,
  localparam int PG_SPAN     = PAGE_BYTES + SPARE_BYTES,
  localparam int TOTAL       = PAGES * PG_SPAN,
  localparam int AW          = $clog2(TOTAL),
  localparam int ROWW        = $clog2(PAGES) + 1,
  localparam int COLW        = $clog2(2 * PAGE_BYTES),
  localparam int CW          = $clog2(PG_SPAN + 1),
  localparam int EW          = $clog2(PG_SPAN << ERASE_SHIFT),
  localparam int BW          = BUS_BYTES * 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [ROWW-1:0] op_row,
  input  logic [COLW-1:0] op_col,
  input  logic            spare_off,
  input  logic            wr_valid,
  input  logic [BW-1:0]   wr_data,
  input  logic            ce_n,
  input  logic            rd_req,
  output logic [BW-1:0]   rd_data,
  output logic            busy
);

  opc_e          opc;
  logic          accept, row_ok;
  logic          open_fill, commit_ok, erase_ok, load_ok, rd_arm;
  logic          mem_we, buf_we;
  logic [AW-1:0] mem_wa;
  logic [7:0]    mem_wd, mem_rdata, buf_wd, buf_rdata;
  logic [CW-1:0] buf_idx, fill_len;
  logic [BW-1:0] rd_bytes;
  logic [AW-1:0] row_base;

  assign opc       = opc_e'(op_code);
  assign accept    = op_valid && !busy;
  assign row_ok    = (op_row < ROWW'(PAGES));
  assign open_fill = accept && (opc == OPC_FILL_OPEN);
  assign commit_ok = accept && (opc == OPC_COMMIT) && row_ok;
  assign erase_ok  = accept && (opc == OPC_ERASE) && row_ok;
  assign load_ok   = accept && (opc == OPC_COPY_LOAD) && row_ok;
  assign rd_arm    = accept && ((opc == OPC_RD_MAIN) || (opc == OPC_RD_UPPER) ||
                                (opc == OPC_RD_SPARE));
  assign row_base  = AW'(op_row) * AW'(PG_SPAN);

  nand_pb_array #(.TOTAL(TOTAL), .AW(AW), .BUS_BYTES(BUS_BYTES)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (mem_we),
    .wa       (mem_wa),
    .wd       (mem_wd),
    .wa_rdata (mem_rdata),
    .rd_base  (rd_ptr_q),
    .rd_bytes (rd_bytes)
  );

  nand_pb_buffer #(.PG_SPAN(PG_SPAN), .CW(CW), .COLW(COLW), .BUS_BYTES(BUS_BYTES)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_fill  (open_fill),
    .copy_start (load_ok),
    .copy_col   (op_col),
    .seal       (commit_ok),
    .hw_valid   (wr_valid && !busy),
    .hw_data    (wr_data),
    .eng_we     (buf_we),
    .eng_idx    (buf_idx),
    .eng_wd     (buf_wd),
    .rd_idx     (buf_idx),
    .rd_byte    (buf_rdata),
    .fill_len   (fill_len)
  );

  nand_pb_engine #(
    .PG_SPAN(PG_SPAN), .ERASE_SHIFT(ERASE_SHIFT), .AW(AW), .ROWW(ROWW),
    .COLW(COLW), .CW(CW), .EW(EW)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_prog   (commit_ok),
    .go_erase  (erase_ok),
    .go_load   (load_ok),
    .row       (op_row),
    .col       (op_col),
    .buf_len   (fill_len),
    .mem_rdata (mem_rdata),
    .buf_rdata (buf_rdata),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_wa    (mem_wa),
    .mem_wd    (mem_wd),
    .buf_we    (buf_we),
    .buf_idx   (buf_idx),
    .buf_wd    (buf_wd)
  );

  // Read position, remaining count and output word
  logic [AW-1:0] rd_ptr_q, rd_ptr_n;
  logic [CW-1:0] rd_cnt_q, rd_cnt_n;
  logic [BW-1:0] rd_data_q, rd_data_n;
  int            preset, start, limit;

  always_comb begin
    rd_ptr_n  = rd_ptr_q;
    rd_cnt_n  = rd_cnt_q;
    rd_data_n = rd_data_q;
    case (opc)
      OPC_RD_UPPER: preset = PAGE_BYTES / 2;
      OPC_RD_SPARE: preset = PAGE_BYTES;
      default:      preset = 0;
    endcase
    start = int'(op_col) + preset;
    limit = spare_off ? PAGE_BYTES : PG_SPAN;
    if (rd_arm) begin
      if (row_ok && start < limit) begin
        rd_cnt_n = CW'(limit - start);
        rd_ptr_n = row_base + AW'(start);
      end else begin
        rd_cnt_n = '0;
        rd_ptr_n = '0;
      end
      if (rd_req) rd_data_n = '0;
    end else if (rd_req) begin
      if (busy || ce_n || rd_cnt_q == '0) begin
        rd_data_n = '0;
      end else begin
        for (int b = 0; b < BUS_BYTES; b++) begin
          rd_data_n[b*8 +: 8] = (b < int'(rd_cnt_q)) ? rd_bytes[b*8 +: 8] : 8'h00;
        end
        rd_ptr_n = rd_ptr_q + AW'(BUS_BYTES);
        rd_cnt_n = (int'(rd_cnt_q) > BUS_BYTES) ? rd_cnt_q - CW'(BUS_BYTES) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q  <= '0;
      rd_cnt_q  <= '0;
      rd_data_q <= '0;
    end else begin
      rd_ptr_q  <= rd_ptr_n;
      rd_cnt_q  <= rd_cnt_n;
      rd_data_q <= rd_data_n;
    end
  end

  assign rd_data = rd_data_q;

endmodule

// File: rtl/nand_page_core_chk.sv
module nand_page_core_chk #(
  parameter int PAGES = 8,
  parameter int ROWW  = 4,
  parameter int BW    = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [2:0]      op_code,
  input logic [ROWW-1:0] op_row,
  input logic            ce_n,
  input logic            rd_req,
  input logic [BW-1:0]   rd_data,
  input logic            busy
);

  logic row_in, row_out, sweep_req;

  assign row_in    = (op_row < ROWW'(PAGES));
  assign row_out   = !row_in;
  assign sweep_req = (op_code == 3'd2) || (op_code == 3'd3) || (op_code == 3'd7);

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_data)); // R12

  AST_CE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && ce_n) |=> (rd_data == '0)); // R8

  AST_BUSY_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && busy) |=> (rd_data == '0)); // R11

  AST_ERASE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_code == 3'd3 && row_in) |=> busy); // R5

  AST_OOR_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && sweep_req && row_out) |=> !busy); // R9

endmodule

bind nand_page_core nand_page_core_chk #(.PAGES(PAGES), .ROWW(ROWW), .BW(BW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_code  (op_code),
  .op_row   (op_row),
  .ce_n     (ce_n),
  .rd_req   (rd_req),
  .rd_data  (rd_data),
  .busy     (busy)
);

// File: tb/tb_nand_page_core.sv
`timescale 1ns/100ps
module tb_nand_page_core;

  localparam int PB = 64;
  localparam int SP = PB >> 5;
  localparam int PS = PB + SP;
  localparam int NP = 8;
  localparam int ES = 2;

  logic        clk, rst_n;
  logic        op_valid, spare_off, wr_valid, ce_n, rd_req, busy;
  logic [2:0]  op_code;
  logic [3:0]  op_row;
  logic [6:0]  op_col;
  logic [15:0] wr_data, rd_data;

  nand_page_core dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_row(op_row), .op_col(op_col), .spare_off(spare_off),
    .wr_valid(wr_valid), .wr_data(wr_data), .ce_n(ce_n), .rd_req(rd_req),
    .rd_data(rd_data), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int errs = 0;
  int checks = 0;
  logic [7:0] model [NP*PS];
  logic [7:0] tbuf [PS];
  int tlen, tptr, tmode;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] pat(int s, int i);
    return 8'((s * 29 + i * 7) ^ 165);
  endfunction

  task automatic op(int code, int row, int col, bit soff);
    op_valid = 1'b1; op_code = 3'(code); op_row = 4'(row); op_col = 7'(col);
    spare_off = soff;
    tick();
    op_valid = 1'b0;
  endtask

  task automatic settle();
    while (busy) tick();
  endtask

  task automatic m_open();
    op(1, 0, 0, 0);
    tlen = 0; tmode = 1;
  endtask

  task automatic m_write(logic [15:0] w);
    for (int b = 0; b < 2; b++) begin
      if (tmode == 1 && tlen + b < PS) tbuf[tlen+b] = w[b*8 +: 8];
      if (tmode == 2 && tptr + b < PS) tbuf[tptr+b] = w[b*8 +: 8];
    end
    if (tmode == 1) tlen = (tlen + 2 >= PS) ? PS : tlen + 2;
    if (tmode == 2) tptr = (tptr + 2 >= PS) ? PS : tptr + 2;
    wr_valid = 1'b1; wr_data = w;
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic m_commit(int row, int col);
    op(2, row, col, 0);
    settle();
    if (row < NP) begin
      for (int i = 0; i < tlen; i++)
        if (col + i < PS) model[row*PS+col+i] = model[row*PS+col+i] & tbuf[i];
      tmode = 0;
    end
  endtask

  task automatic m_erase_model(int row);
    for (int p = (row >> ES) << ES; p < ((row >> ES) << ES) + (1 << ES); p++)
      for (int i = 0; i < PS; i++) model[p*PS+i] = 8'hFF;
  endtask

  task automatic m_load(int row, int col);
    op(7, row, col, 0);
    settle();
    if (row < NP) begin
      for (int i = 0; i < PS; i++) tbuf[i] = model[row*PS+i];
      tlen = PS; tptr = col; tmode = 2;
    end
  endtask

  task automatic rd_word(output logic [15:0] w);
    rd_req = 1'b1;
    tick();
    rd_req = 1'b0;
    w = rd_data;
  endtask

  task automatic verify(int code, int row, int col, bit soff, string req);
    int preset, start, lim, cnt, ptr;
    logic [15:0] w, e;
    preset = (code == 5) ? PB / 2 : (code == 6) ? PB : 0;
    start  = col + preset;
    lim    = soff ? PB : PS;
    cnt    = (row < NP && start < lim) ? lim - start : 0;
    ptr    = row * PS + start;
    op(code, row, col, soff);
    while (cnt > 0) begin
      rd_word(w);
      e = {(cnt >= 2) ? model[ptr+1] : 8'h00, model[ptr]};
      chk(req, 32'(w), 32'(e));
      ptr += 2;
      cnt = (cnt > 2) ? cnt - 2 : 0;
    end
    rd_word(w);
    chk({req, " R7 exhausted"}, 32'(w), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog R11 actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] w, held;
    op_valid = 0; op_code = 0; op_row = 0; op_col = 0; spare_off = 0;
    wr_valid = 0; wr_data = 0; ce_n = 0; rd_req = 0; rst_n = 0;
    tlen = 0; tptr = 0; tmode = 0;
    for (int i = 0; i < NP*PS; i++) model[i] = 8'hFF;
    for (int i = 0; i < PS; i++) tbuf[i] = 8'h00;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R1 reset state
    chk("R1 rd_data", 32'(rd_data), 32'h0);
    chk("R1 busy", 32'(busy), 32'h0);
    rd_word(w);
    chk("R1 unarmed read", 32'(w), 32'h0);
    verify(4, 0, 0, 0, "R1");
    // R2 spare area is two bytes beyond the main area
    verify(6, 5, 0, 0, "R2");

    // R3 R4 sweep every page with its own pattern
    for (int p = 0; p < NP; p++) begin
      m_open();
      for (int k = 0; k < 33; k++) m_write({pat(p, 2*k+1), pat(p, 2*k)});
      m_commit(p, 0);
      verify(4, p, 0, 0, "R4");
    end
    // R4 AND at an inner column
    m_open();
    for (int k = 0; k < 10; k++) m_write({pat(50, 2*k+1), pat(50, 2*k)});
    m_commit(2, 5);
    verify(4, 2, 0, 0, "R4");
    // R4 stop at the end of the page
    m_open();
    for (int k = 0; k < 5; k++) m_write({pat(60, 2*k+1), pat(60, 2*k)});
    m_commit(3, 60);
    verify(4, 3, 0, 0, "R4");

    // R5 erase of a page in the upper block
    op(3, 5, 0, 0);
    settle();
    m_erase_model(5);
    verify(4, 3, 0, 0, "R5");
    verify(4, 4, 0, 0, "R5");
    verify(4, 7, 0, 0, "R5");

    // R3 overflow of the buffer
    m_open();
    for (int k = 0; k < 40; k++) m_write({pat(70, 2*k+1), pat(70, 2*k)});
    m_commit(6, 0);
    verify(4, 6, 0, 0, "R3");

    // R6 read start and length variants
    verify(5, 6, 3, 0, "R6");
    verify(6, 6, 0, 0, "R6");
    verify(6, 6, 1, 0, "R6");
    verify(4, 6, 10, 1, "R6");
    verify(6, 6, 0, 1, "R6");
    verify(4, 6, 70, 0, "R6");

    // R8 chip enable high
    op(4, 6, 0, 0);
    ce_n = 1;
    rd_word(w);
    chk("R8 ce_n high", 32'(w), 32'h0);
    ce_n = 0;
    rd_word(w);
    chk("R8 no advance", 32'(w), 32'({model[6*PS+1], model[6*PS]}));
    // R12 hold without strobe
    held = rd_data;
    repeat (3) tick();
    chk("R12 hold", 32'(rd_data), 32'(held));

    // R9 pages past the array
    op(3, 9, 0, 0);
    chk("R9 erase ignored", 32'(busy), 32'h0);
    m_open();
    m_write(16'h0000);
    op(2, 9, 0, 0);
    chk("R9 commit ignored", 32'(busy), 32'h0);
    op(7, 9, 0, 0);
    chk("R9 load ignored", 32'(busy), 32'h0);
    verify(4, 9, 0, 0, "R9");
    verify(4, 1, 0, 0, "R9");

    // R10 copyback with edits
    m_load(1, 10);
    for (int k = 0; k < 3; k++) m_write({pat(80, 2*k+1), pat(80, 2*k)});
    m_commit(4, 0);
    verify(4, 4, 0, 0, "R10");
    m_load(1, 64);
    for (int k = 0; k < 2; k++) m_write({pat(81, 2*k+1), pat(81, 2*k)});
    m_commit(7, 0);
    verify(4, 7, 0, 0, "R10");

    // R11 read strobe and request during an erase sweep
    op(4, 6, 0, 0);
    op(3, 0, 0, 0);
    chk("R11 busy", 32'(busy), 32'h1);
    rd_word(w);
    chk("R11 read while busy", 32'(w), 32'h0);
    op(2, 2, 0, 0);
    settle();
    m_erase_model(0);
    rd_word(w);
    chk("R11 position held", 32'(w), 32'({model[6*PS+1], model[6*PS]}));
    verify(4, 2, 0, 0, "R11");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule